// File: doc/BRIEF.md
# Windowed Threshold Alert Unit

This unit sits behind a background conversion sequencer and checks every fresh sample against a window. Each window is set per channel and has a lower bound, an upper bound and a hysteresis band. The sequencer delivers a one-cycle valid strobe with a channel index and a 12-bit sample. For each direction, the unit keeps a sticky per-channel flag: one for samples above the window and one for samples below it. From these flags it drives a level-sensitive alert line.

Software programs the unit through a byte-wide register port. That port holds the following:
- a global comparator enable;
- an alert mask with one bit per channel;
- two write-one-to-clear flag registers;
- four bytes per channel for the limits.

Each limit is split over two bytes. The first byte carries the four least significant bits of the limit in its upper nibble. The second byte carries bits 11..4. The upper-limit first byte also carries the hysteresis code in its lower nibble. While the sampled signal stays outside the window, each new sample sets its flag again, so the alert returns after software clears it. A direction is turned off by moving its limit to the end of the code range.

Top module: `win_alert_unit`

## Requirements
- R1: After reset, the following hold: both flag registers read 0, `alert_o` is 0, the enable and the mask read 0, every upper limit is 4095, every lower limit is 0 and every hysteresis code is 0.
- R2: The registers sit at these addresses. The enable is bit 0 of address 0x00. The mask is at 0x01. The upper flags are at 0x02 and the lower flags at 0x03, with bit n standing for channel n. For channel n the limit bytes are:
  - 0x10+4n: upper-limit bits 3..0 in [7:4] and the hysteresis code in [3:0];
  - 0x11+4n: upper-limit bits 11..4;
  - 0x12+4n: lower-limit bits 3..0 in [7:4], with [3:0] reading 0;
  - 0x13+4n: lower-limit bits 11..4.
  
  All of these bytes read back what was written. Unmapped addresses read 0.
- R3: A channel in its armed state violates high when the sample is greater than its upper limit. It violates low when the sample is less than its lower limit. A violation becomes visible in the flag registers on the cycle after the strobe.
- R4: After a high violation, the channel keeps violating high until a sample satisfies sample + 8*code <= upper limit. After a low violation, it keeps violating low until a sample satisfies sample >= lower limit + 8*code. This tracking runs on every sample for the channel, whatever the enable and mask settings.
- R5: A violation sets its flag only when the comparator enable is 1 and the channel's mask bit is 1.
- R6: Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged. A cleared flag is set again by the next violating sample.
- R7: When a clearing write and a violation for the same flag bit fall in the same cycle, the flag ends up set.
- R8: `alert_o` is 1 exactly when the enable is 1 and some channel with its mask bit set has either flag set. The output follows the flags, the mask and the enable with no extra delay.
- R9: An upper limit of 4095 never produces a high violation, and a lower limit of 0 never produces a low violation, whatever the hysteresis state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| res_valid_i | input | 1 | New sample strobe |
| res_chan_i | input | 3 | Channel of the sample |
| res_data_i | input | 12 | Sample value |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational from the address |
| alert_o | output | 1 | Level alert |

## Verification
The bench sweeps samples up and then down across all 4096 codes on every channel. Each channel has its own window and hysteresis code, and flags are cleared at intervals during the sweep. A design that compares against the limit directly would fail here, because it would drop flags inside the hysteresis band. A design that never re-arms would also fail, because it would keep flagging after the sample has returned.

Directed cases cover the following:
- a clearing write landing in the same cycle as a violation, where a design with clear priority would lose the event;
- extreme limits reached while a channel is still tripped, where a design that did not force the direction off would still raise alerts;
- masked and disabled channels, where a design that gated only the alert would still set flags.

// File: rtl/win_alert_pkg.sv
package win_alert_pkg;
  localparam int unsigned REG_AW = 8;
  localparam int unsigned REG_DW = 8;

  localparam logic [REG_AW-1:0] ADR_CTRL     = 8'h00;
  localparam logic [REG_AW-1:0] ADR_MASK     = 8'h01;
  localparam logic [REG_AW-1:0] ADR_FLAG_HI  = 8'h02;
  localparam logic [REG_AW-1:0] ADR_FLAG_LO  = 8'h03;
  localparam logic [REG_AW-1:0] ADR_LIM_BASE = 8'h10;

  typedef enum logic [1:0] {
    LIM_HI_LSN = 2'd0,
    LIM_HI_MSB = 2'd1,
    LIM_LO_LSN = 2'd2,
    LIM_LO_MSB = 2'd3
  } lim_byte_e;

  function automatic logic [REG_AW-1:0] lim_addr(int unsigned ch, lim_byte_e b);
    return ADR_LIM_BASE + REG_AW'(ch * 4) + REG_AW'(b);
  endfunction
endpackage

// File: rtl/win_alert_regs.sv
module win_alert_regs
  import win_alert_pkg::*;
#(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned DATA_W = 12,
  parameter int unsigned HYST_W = 4
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              wr_i,
  input  logic [REG_AW-1:0]                 addr_i,
  input  logic [REG_DW-1:0]                 wdata_i,
  input  logic [NUM_CH-1:0]                 flag_hi_i,
  input  logic [NUM_CH-1:0]                 flag_lo_i,
  output logic [REG_DW-1:0]                 rdata_o,
  output logic                              cmp_en_o,
  output logic [NUM_CH-1:0]                 ch_mask_o,
  output logic [NUM_CH-1:0][DATA_W-1:0]     hi_lim_o,
  output logic [NUM_CH-1:0][DATA_W-1:0]     lo_lim_o,
  output logic [NUM_CH-1:0][HYST_W-1:0]     hyst_o
);
  localparam int unsigned LSN_W = DATA_W - REG_DW;
  localparam int unsigned PAD_W = REG_DW - LSN_W - HYST_W;
  localparam int unsigned LPAD_W = REG_DW - LSN_W;

  logic              en_q;
  logic [NUM_CH-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      mask_q <= '0;
    end else if (wr_i) begin
      if (addr_i == ADR_CTRL) en_q   <= wdata_i[0];
      if (addr_i == ADR_MASK) mask_q <= wdata_i[NUM_CH-1:0];
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [DATA_W-1:0] hi_q, lo_q;
    logic [HYST_W-1:0] hy_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        hi_q <= '1;
        lo_q <= '0;
        hy_q <= '0;
      end else if (wr_i) begin
        if (addr_i == lim_addr(c, LIM_HI_LSN)) begin
          hi_q[LSN_W-1:0] <= wdata_i[REG_DW-1 -: LSN_W];
          hy_q            <= wdata_i[HYST_W-1:0];
        end
        if (addr_i == lim_addr(c, LIM_HI_MSB)) hi_q[DATA_W-1:LSN_W] <= wdata_i;
        if (addr_i == lim_addr(c, LIM_LO_LSN)) lo_q[LSN_W-1:0]      <= wdata_i[REG_DW-1 -: LSN_W];
        if (addr_i == lim_addr(c, LIM_LO_MSB)) lo_q[DATA_W-1:LSN_W] <= wdata_i;
      end
    end

    assign hi_lim_o[c] = hi_q;
    assign lo_lim_o[c] = lo_q;
    assign hyst_o[c]   = hy_q;
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADR_CTRL:    rdata_o = REG_DW'(en_q);
      ADR_MASK:    rdata_o = REG_DW'(mask_q);
      ADR_FLAG_HI: rdata_o = REG_DW'(flag_hi_i);
      ADR_FLAG_LO: rdata_o = REG_DW'(flag_lo_i);
      default: begin
        for (int c = 0; c < NUM_CH; c++) begin
          if (addr_i == lim_addr(c, LIM_HI_LSN))
            rdata_o = {hi_lim_o[c][LSN_W-1:0], {PAD_W{1'b0}}, hyst_o[c]};
          if (addr_i == lim_addr(c, LIM_HI_MSB))
            rdata_o = hi_lim_o[c][DATA_W-1:LSN_W];
          if (addr_i == lim_addr(c, LIM_LO_LSN))
            rdata_o = {lo_lim_o[c][LSN_W-1:0], {LPAD_W{1'b0}}};
          if (addr_i == lim_addr(c, LIM_LO_MSB))
            rdata_o = lo_lim_o[c][DATA_W-1:LSN_W];
        end
      end
    endcase
  end

  assign cmp_en_o  = en_q;
  assign ch_mask_o = mask_q;
endmodule

// File: rtl/win_alert_cmp.sv
module win_alert_cmp #(
  parameter int unsigned NUM_CH     = 8,
  parameter int unsigned DATA_W     = 12,
  parameter int unsigned HYST_W     = 4,
  parameter int unsigned HYST_SHIFT = 3
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          res_valid_i,
  input  logic [$clog2(NUM_CH)-1:0]     res_chan_i,
  input  logic [DATA_W-1:0]             res_data_i,
  input  logic [NUM_CH-1:0][DATA_W-1:0] hi_lim_i,
  input  logic [NUM_CH-1:0][DATA_W-1:0] lo_lim_i,
  input  logic [NUM_CH-1:0][HYST_W-1:0] hyst_i,
  output logic [NUM_CH-1:0]             hi_viol_o,
  output logic [NUM_CH-1:0]             lo_viol_o
);
  localparam int unsigned CH_W  = $clog2(NUM_CH);
  localparam int unsigned CMP_W = DATA_W + 2;

  logic [CMP_W-1:0] data_x;
  assign data_x = CMP_W'(res_data_i);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic             sel;
    logic             hi_trip_q, lo_trip_q;
    logic             hi_off, lo_off;
    logic [CMP_W-1:0] band, hi_x, lo_x;

    assign sel    = res_valid_i && (res_chan_i == CH_W'(c));
    assign band   = CMP_W'(hyst_i[c]) << HYST_SHIFT;
    assign hi_x   = CMP_W'(hi_lim_i[c]);
    assign lo_x   = CMP_W'(lo_lim_i[c]);
    // extreme limits switch the direction off even while tripped
    assign hi_off = &hi_lim_i[c];
    assign lo_off = ~|lo_lim_i[c];

    assign hi_viol_o[c] = sel && !hi_off &&
                          (hi_trip_q ? (data_x + band > hi_x) : (data_x > hi_x));
    assign lo_viol_o[c] = sel && !lo_off &&
                          (lo_trip_q ? (data_x < lo_x + band) : (data_x < lo_x));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        hi_trip_q <= 1'b0;
        lo_trip_q <= 1'b0;
      end else if (sel) begin
        hi_trip_q <= hi_viol_o[c];
        lo_trip_q <= lo_viol_o[c];
      end
    end
  end
endmodule

// File: rtl/win_alert_flags.sv
module win_alert_flags
  import win_alert_pkg::*;
#(
  parameter int unsigned NUM_CH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] set_hi_i,
  input  logic [NUM_CH-1:0] set_lo_i,
  input  logic              wr_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [REG_DW-1:0] wdata_i,
  input  logic              cmp_en_i,
  input  logic [NUM_CH-1:0] ch_mask_i,
  output logic [NUM_CH-1:0] flag_hi_o,
  output logic [NUM_CH-1:0] flag_lo_o,
  output logic              alert_o
);
  logic [NUM_CH-1:0] clr_hi, clr_lo;

  assign clr_hi = (wr_i && addr_i == ADR_FLAG_HI) ? wdata_i[NUM_CH-1:0] : '0;
  assign clr_lo = (wr_i && addr_i == ADR_FLAG_LO) ? wdata_i[NUM_CH-1:0] : '0;

  // set wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_hi_o <= '0;
      flag_lo_o <= '0;
    end else begin
      flag_hi_o <= (flag_hi_o & ~clr_hi) | set_hi_i;
      flag_lo_o <= (flag_lo_o & ~clr_lo) | set_lo_i;
    end
  end

  assign alert_o = cmp_en_i && |((flag_hi_o | flag_lo_o) & ch_mask_i);
endmodule

// File: rtl/win_alert_unit.sv
module win_alert_unit
  import win_alert_pkg::*;
#(
  parameter int unsigned NUM_CH     = 8,
  parameter int unsigned DATA_W     = 12,
  parameter int unsigned HYST_W     = 4,
  parameter int unsigned HYST_SHIFT = 3
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      res_valid_i,
  input  logic [$clog2(NUM_CH)-1:0] res_chan_i,
  input  logic [DATA_W-1:0]         res_data_i,
  input  logic                      reg_wr_i,
  input  logic [REG_AW-1:0]         reg_addr_i,
  input  logic [REG_DW-1:0]         reg_wdata_i,
  output logic [REG_DW-1:0]         reg_rdata_o,
  output logic                      alert_o
);
  logic                          cmp_en;
  logic [NUM_CH-1:0]             ch_mask;
  logic [NUM_CH-1:0][DATA_W-1:0] hi_lim, lo_lim;
  logic [NUM_CH-1:0][HYST_W-1:0] hyst;
  logic [NUM_CH-1:0]             hi_viol, lo_viol, set_hi, set_lo;
  logic [NUM_CH-1:0]             flag_hi, flag_lo;

  win_alert_regs #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .HYST_W(HYST_W)) i_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (reg_wr_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .flag_hi_i (flag_hi),
    .flag_lo_i (flag_lo),
    .rdata_o   (reg_rdata_o),
    .cmp_en_o  (cmp_en),
    .ch_mask_o (ch_mask),
    .hi_lim_o  (hi_lim),
    .lo_lim_o  (lo_lim),
    .hyst_o    (hyst)
  );

  win_alert_cmp #(
    .NUM_CH(NUM_CH), .DATA_W(DATA_W), .HYST_W(HYST_W), .HYST_SHIFT(HYST_SHIFT)
  ) i_cmp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .res_valid_i (res_valid_i),
    .res_chan_i  (res_chan_i),
    .res_data_i  (res_data_i),
    .hi_lim_i    (hi_lim),
    .lo_lim_i    (lo_lim),
    .hyst_i      (hyst),
    .hi_viol_o   (hi_viol),
    .lo_viol_o   (lo_viol)
  );

  assign set_hi = hi_viol & ch_mask & {NUM_CH{cmp_en}};
  assign set_lo = lo_viol & ch_mask & {NUM_CH{cmp_en}};

  win_alert_flags #(.NUM_CH(NUM_CH)) i_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_hi_i  (set_hi),
    .set_lo_i  (set_lo),
    .wr_i      (reg_wr_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .cmp_en_i  (cmp_en),
    .ch_mask_i (ch_mask),
    .flag_hi_o (flag_hi),
    .flag_lo_o (flag_lo),
    .alert_o   (alert_o)
  );
endmodule

// File: rtl/win_alert_chk.sv
module win_alert_chk #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned DATA_W = 12
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          res_valid_i,
  input logic [$clog2(NUM_CH)-1:0]     res_chan_i,
  input logic                          alert_o,
  input logic                          cmp_en,
  input logic [NUM_CH-1:0]             ch_mask,
  input logic [NUM_CH-1:0]             hi_viol,
  input logic [NUM_CH-1:0]             lo_viol,
  input logic [NUM_CH-1:0]             set_hi,
  input logic [NUM_CH-1:0]             set_lo,
  input logic [NUM_CH-1:0]             flag_hi,
  input logic [NUM_CH-1:0]             flag_lo,
  input logic [NUM_CH-1:0][DATA_W-1:0] hi_lim,
  input logic [NUM_CH-1:0][DATA_W-1:0] lo_lim
);
  // R8
  alert_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alert_o |-> cmp_en);

  // R8
  alert_needs_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alert_o |-> |((flag_hi | flag_lo) & ch_mask));

  // R7
  set_wins_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |set_hi |=> ((flag_hi & $past(set_hi)) == $past(set_hi)));

  // R7
  set_wins_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |set_lo |=> ((flag_lo & $past(set_lo)) == $past(set_lo)));

  // R5
  flag_rise_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |((flag_hi & ~$past(flag_hi)) | (flag_lo & ~$past(flag_lo)))
      |-> $past(res_valid_i && cmp_en));

  // R9
  hi_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_i && (&hi_lim[res_chan_i])) |-> !hi_viol[res_chan_i]);

  // R9
  lo_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_i && !(|lo_lim[res_chan_i])) |-> !lo_viol[res_chan_i]);
endmodule

bind win_alert_unit win_alert_chk #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) i_win_alert_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .res_valid_i (res_valid_i),
  .res_chan_i  (res_chan_i),
  .alert_o     (alert_o),
  .cmp_en      (cmp_en),
  .ch_mask     (ch_mask),
  .hi_viol     (hi_viol),
  .lo_viol     (lo_viol),
  .set_hi      (set_hi),
  .set_lo      (set_lo),
  .flag_hi     (flag_hi),
  .flag_lo     (flag_lo),
  .hi_lim      (hi_lim),
  .lo_lim      (lo_lim)
);

// File: tb/test_win_alert_unit.sv
`timescale 1ns/1ps
module test_win_alert_unit;
  import win_alert_pkg::*;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       res_valid_i = 1'b0;
  logic [2:0] res_chan_i = '0;
  logic [11:0] res_data_i = '0;
  logic       reg_wr_i = 1'b0;
  logic [7:0] reg_addr_i = '0;
  logic [7:0] reg_wdata_i = '0;
  logic [7:0] reg_rdata_o;
  logic       alert_o;

  int checks = 0;
  int errors = 0;

  // bench model
  int   m_hi[8], m_lo[8], m_hy[8];
  bit   m_ht[8], m_lt[8];
  bit   m_en;
  logic [7:0] m_mask, m_fh, m_fl;

  always #2.5 clk_i = ~clk_i;

  win_alert_unit i_win_alert_unit (
    .clk_i(clk_i), .rst_ni(rst_ni), .res_valid_i(res_valid_i), .res_chan_i(res_chan_i),
    .res_data_i(res_data_i), .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .alert_o(alert_o)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] v);
    @(negedge clk_i);
    reg_addr_i = a;
    #1 v = reg_rdata_o;
  endtask

  task automatic model_clear(logic [7:0] a, logic [7:0] d);
    if (a == ADR_FLAG_HI) m_fh &= ~d;
    if (a == ADR_FLAG_LO) m_fl &= ~d;
    if (a == ADR_CTRL) m_en = d[0];
    if (a == ADR_MASK) m_mask = d;
  endtask

  task automatic model_res(int ch, int d);
    int  h;
    bit  hv, lv;
    h  = m_hy[ch] * 8;
    hv = (m_hi[ch] != 4095) && (m_ht[ch] ? (d + h > m_hi[ch]) : (d > m_hi[ch]));
    lv = (m_lo[ch] != 0) && (m_lt[ch] ? (d < m_lo[ch] + h) : (d < m_lo[ch]));
    m_ht[ch] = hv;
    m_lt[ch] = lv;
    if (m_en && m_mask[ch]) begin
      if (hv) m_fh[ch] = 1'b1;
      if (lv) m_fl[ch] = 1'b1;
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk_i);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_wr_i = 1'b0;
    model_clear(a, d);
  endtask

  task automatic check_state(string tag);
    logic [7:0] v;
    rd(ADR_FLAG_HI, v);
    chk({tag, " high flags"}, v, m_fh);
    rd(ADR_FLAG_LO, v);
    chk({tag, " low flags"}, v, m_fl);
    chk({"R8 alert after ", tag}, alert_o, int'(m_en && |((m_fh | m_fl) & m_mask)));
  endtask

  task automatic send(int ch, int d, string tag);
    @(negedge clk_i);
    res_valid_i = 1'b1; res_chan_i = 3'(ch); res_data_i = 12'(d);
    @(negedge clk_i);
    res_valid_i = 1'b0;
    model_res(ch, d);
    check_state(tag);
  endtask

  // clear write and sample strobe in the same cycle
  task automatic send_with_clear(int ch, int d, logic [7:0] a, logic [7:0] msk);
    @(negedge clk_i);
    res_valid_i = 1'b1; res_chan_i = 3'(ch); res_data_i = 12'(d);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = msk;
    @(negedge clk_i);
    res_valid_i = 1'b0; reg_wr_i = 1'b0;
    model_clear(a, msk);
    model_res(ch, d);
    check_state("R7");
  endtask

  task automatic set_lim(int ch, logic [11:0] hi, logic [11:0] lo, logic [3:0] hy);
    logic [7:0] v;
    wr(lim_addr(ch, LIM_HI_LSN), {hi[3:0], hy});
    wr(lim_addr(ch, LIM_HI_MSB), hi[11:4]);
    wr(lim_addr(ch, LIM_LO_LSN), {lo[3:0], 4'h0});
    wr(lim_addr(ch, LIM_LO_MSB), lo[11:4]);
    m_hi[ch] = hi; m_lo[ch] = lo; m_hy[ch] = hy;
    rd(lim_addr(ch, LIM_HI_LSN), v); chk("R2 high first byte", v, {hi[3:0], hy});
    rd(lim_addr(ch, LIM_HI_MSB), v); chk("R2 high second byte", v, hi[11:4]);
    rd(lim_addr(ch, LIM_LO_LSN), v); chk("R2 low first byte", v, {lo[3:0], 4'h0});
    rd(lim_addr(ch, LIM_LO_MSB), v); chk("R2 low second byte", v, lo[11:4]);
  endtask

  initial begin
    #750000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int k;
    for (int c = 0; c < 8; c++) begin
      m_hi[c] = 4095; m_lo[c] = 0; m_hy[c] = 0; m_ht[c] = 0; m_lt[c] = 0;
    end
    m_en = 0; m_mask = 0; m_fh = 0; m_fl = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    rd(ADR_CTRL, v);    chk("R1 enable", v, 0);
    rd(ADR_MASK, v);    chk("R1 mask", v, 0);
    rd(ADR_FLAG_HI, v); chk("R1 high flags", v, 0);
    rd(ADR_FLAG_LO, v); chk("R1 low flags", v, 0);
    chk("R1 alert", alert_o, 0);
    for (int c = 0; c < 8; c++) begin
      rd(lim_addr(c, LIM_HI_LSN), v); chk("R1 high limit low nibble", v, 8'hF0);
      rd(lim_addr(c, LIM_HI_MSB), v); chk("R1 high limit upper bits", v, 8'hFF);
      rd(lim_addr(c, LIM_LO_LSN), v); chk("R1 low limit low nibble", v, 8'h00);
      rd(lim_addr(c, LIM_LO_MSB), v); chk("R1 low limit upper bits", v, 8'h00);
    end
    rd(8'h7F, v); chk("R2 unmapped", v, 0);

    wr(ADR_CTRL, 8'h01);
    wr(ADR_MASK, 8'hFF);
    rd(ADR_CTRL, v); chk("R2 enable readback", v, 1);
    rd(ADR_MASK, v); chk("R2 mask readback", v, 8'hFF);

    // R3 R4 sweeps with per-channel windows and hysteresis
    k = 0;
    for (int c = 0; c < 8; c++) begin
      set_lim(c, 12'(300 + 211*c + 900 + 37*c), 12'(300 + 211*c), 4'(2*c + 1));
      for (int d = 0; d < 4096; d += 41) begin
        send(c, d, "R3 R4 rising sweep");
        k++;
        if (k % 5 == 0) begin wr(ADR_FLAG_HI, 8'hFF); wr(ADR_FLAG_LO, 8'hFF); end
      end
      for (int d = 4095; d >= 0; d -= 53) begin
        send(c, d, "R3 R4 falling sweep");
        k++;
        if (k % 5 == 0) begin wr(ADR_FLAG_HI, 8'hFF); wr(ADR_FLAG_LO, 8'hFF); end
      end
    end

    // R4 explicit band on channel 6: high 2000, low 1000, band 32
    set_lim(6, 12'd2000, 12'd1000, 4'd4);
    send(6, 1500, "R4 inside");
    wr(ADR_FLAG_HI, 8'hFF); wr(ADR_FLAG_LO, 8'hFF);
    send(6, 2001, "R3 just above");
    wr(ADR_FLAG_HI, 8'hFF);
    send(6, 1990, "R4 within band");
    wr(ADR_FLAG_HI, 8'hFF);
    send(6, 1968, "R4 back at edge");
    send(6, 1990, "R4 rearmed");
    send(6, 999, "R3 just below");
    wr(ADR_FLAG_LO, 8'hFF);
    send(6, 1031, "R4 low band");
    wr(ADR_FLAG_LO, 8'hFF);
    send(6, 1032, "R4 low back");
    send(6, 1010, "R4 low rearmed");

    // R5 enable and mask gating
    wr(ADR_FLAG_HI, 8'hFF); wr(ADR_FLAG_LO, 8'hFF);
    wr(ADR_CTRL, 8'h00);
    send(2, 4000, "R5 disabled");
    send(2, 10, "R5 disabled low");
    wr(ADR_CTRL, 8'h01);
    wr(ADR_MASK, 8'hF7);
    send(3, 4000, "R5 masked channel");
    send(4, 4000, "R5 selected channel");

    // R8 alert follows mask and enable
    wr(ADR_MASK, 8'h00);
    check_state("R8 mask cleared");
    wr(ADR_MASK, 8'h10);
    check_state("R8 mask restored");
    wr(ADR_CTRL, 8'h00);
    check_state("R8 enable off");
    wr(ADR_CTRL, 8'h01);
    wr(ADR_MASK, 8'hFF);

    // R6 write-one-to-clear
    wr(ADR_FLAG_HI, 8'h00);
    check_state("R6 zero write");
    wr(ADR_FLAG_HI, 8'h10);
    check_state("R6 one write");
    send(4, 4000, "R6 set again");

    // R7 set beats clear; clear alone still works
    send_with_clear(4, 4001, ADR_FLAG_HI, 8'h10);
    send_with_clear(4, 2000, ADR_FLAG_HI, 8'h10);

    // R9 extreme limits, including a tripped channel
    wr(ADR_FLAG_HI, 8'hFF); wr(ADR_FLAG_LO, 8'hFF);
    send(1, 4095, "R9 trip high first");
    send(1, 0, "R9 trip low first");
    set_lim(1, 12'd4095, 12'd0, 4'd15);
    wr(ADR_FLAG_HI, 8'hFF); wr(ADR_FLAG_LO, 8'hFF);
    send(1, 4095, "R9 top code");
    send(1, 0, "R9 bottom code");
    send(1, 4000, "R9 high band");
    send(1, 50, "R9 low band");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule